// File: doc/BRIEF.md
# Interrupt-Wakeable Core Clock Gate Controller

This block owns the general configuration register of a core and, inside it, the power-up bit that decides whether the core's distributed clock runs. A host bus writes the whole register through a simple write port. The core's own processor can only write the power-up bit, through a strobe. A value of 0 in that bit stops the gated clock and with it the processor.

Once the clock is stopped, the processor can no longer act. Two paths reopen the gate. The first is a rising edge on one of the interrupt inputs. These inputs are asynchronous, so they are first synchronized on the free-running clock. The second is a host write of 1, because the host port runs on the free-running clock.

The block drives a clock-enable for a glitch-free gating cell. That enable is retimed on the falling clock edge, so it only moves while the clock is low. A status output shows whether the core is currently gated off.

Top module: `cgate_top`

## Requirements
- R1: After reset the power-up bit is 1, `clkEn` is 1, `clkGated` is 0, and every other bit of `cfgOut` is 0.
- R2: A host write (`hostWe`=1) to address `CFG_ADDR` (default 4'hB) loads `hostWdata` into `cfgOut`, and bit `PU_BIT` (default 0) of that word becomes the power-up bit. This holds whether the clock is running or stopped. `clkEn` takes the new value at the falling edge that follows the capturing rising edge.
- R3: A host write to any other address changes neither `cfgOut` nor `clkEn`.
- R4: A processor write (`cpuWe`=1) loads `cpuWdata` into the power-up bit only while the bit is 1. While the bit is 0, the write is ignored. A processor write never changes the other register bits.
- R5: When the host and the processor write the register in the same cycle, the host value is taken.
- R6: A low-to-high transition on any bit of `irqIn` sets the power-up bit. The transition passes two synchronizer flops and one edge flop. If the input rises before rising edge n, the bit is set at edge n+2 and `clkEn` goes to 1 at the falling edge after it.
- R7: An interrupt input that stays high does not wake the clock again after it has been cleared. Only a new rising transition does.
- R8: If a wake edge and a clear by host or processor land on the same rising edge, the wake wins and the bit stays 1.
- R9: `clkEn` changes only while `clk` is low. At every rising edge it equals the power-up bit.
- R10: `clkGated` is always the inverse of `clkEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host write address |
| hostWdata | input | DATA_W | Host write data |
| cpuWe | input | 1 | Processor write strobe for the power-up bit |
| cpuWdata | input | 1 | Processor power-up bit value |
| irqIn | input | NUM_IRQ | Asynchronous interrupt lines |
| cfgOut | output | DATA_W | Configuration register contents |
| clkEn | output | 1 | Enable for the clock-gating cell |
| clkGated | output | 1 | 1 while the core clock is stopped |

## Verification
The hardest case to reach is the collision of a wake edge with a clear. The edge only exists inside the block, two flops after the input has moved. To hit it, the bench raises an interrupt and counts exactly two rising edges. It then presents a host clear so that the clear is captured on the same rising edge as the wake. One cycle later it repeats the clear, to show that the clear does work once the edge has passed. A second hard case is an interrupt held high across a clear, which must not wake the clock. This is reached by clearing the bit while the line is still high.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
  typedef struct packed {
    logic setPu;    // force power-up bit to 1
    logic clrPu;    // force power-up bit to 0
    logic loadCfg;  // load host word into the register
  } cgateStrobe_t;
endpackage

// File: rtl/cgate_ctrl.sv
module cgate_ctrl #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CFG_ADDR    = 11,
  parameter int PU_BIT      = 0,
  parameter int NUM_IRQ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWe,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic                 cpuWe,
  input  logic                 cpuWdata,
  input  logic [NUM_IRQ-1:0]   irqIn,
  input  logic                 puBit,
  output cgate_pkg::cgateStrobe_t strobe
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_IRQ-1:0] wakeEdge;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [CHAIN_W-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[CHAIN_W-2:0], irqIn[i]};
    end
    assign wakeEdge[i] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end

  logic wake, hostHit, cpuLive, newBit, anyWrite;

  always_comb begin
    wake     = |wakeEdge;
    hostHit  = hostWe && (hostAddr == ADDR_W'(CFG_ADDR));
    cpuLive  = cpuWe && puBit;
    anyWrite = hostHit || cpuLive;
    newBit   = hostHit ? hostWdata[PU_BIT] : cpuWdata;
    strobe.loadCfg = hostHit;
    strobe.setPu   = wake || (anyWrite && newBit);
    strobe.clrPu   = !wake && anyWrite && !newBit;
  end
endmodule

// File: rtl/cgate_dp.sv
module cgate_dp #(
  parameter int DATA_W = 8,
  parameter int PU_BIT = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cgate_pkg::cgateStrobe_t strobe,
  input  logic [DATA_W-1:0]       hostWdata,
  output logic [DATA_W-1:0]       cfgReg,
  output logic                    puBit,
  output logic                    clkEn
);
  localparam logic [DATA_W-1:0] RESET_CFG = DATA_W'(1) << PU_BIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= RESET_CFG;
    end else begin
      if (strobe.loadCfg) cfgReg <= hostWdata;
      if (strobe.setPu)      cfgReg[PU_BIT] <= 1'b1;
      else if (strobe.clrPu) cfgReg[PU_BIT] <= 1'b0;
    end
  end

  assign puBit = cfgReg[PU_BIT];

  // retimed on the falling edge: enable moves only while the clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) clkEn <= 1'b1;
    else       clkEn <= puBit;
  end
endmodule

// File: rtl/cgate_top.sv
module cgate_top #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CFG_ADDR    = 11,
  parameter int PU_BIT      = 0,
  parameter int NUM_IRQ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic               cpuWe,
  input  logic               cpuWdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic [DATA_W-1:0]  cfgOut,
  output logic               clkEn,
  output logic               clkGated
);
  cgate_pkg::cgateStrobe_t strobe;
  logic puBit;

  cgate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .PU_BIT(PU_BIT), .NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .cpuWe(cpuWe), .cpuWdata(cpuWdata),
    .irqIn(irqIn), .puBit(puBit), .strobe(strobe)
  );

  cgate_dp #(.DATA_W(DATA_W), .PU_BIT(PU_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(hostWdata),
    .cfgReg(cfgOut), .puBit(puBit), .clkEn(clkEn)
  );

  assign clkGated = ~clkEn;
endmodule

// File: rtl/cgate_chk.sv
module cgate_chk (
  input logic clk,
  input logic rstN,
  input logic puBit,
  input logic clkEn,
  input logic setPu,
  input logic clrPu,
  input logic cpuWe
);
  // R8: a set (including a wake) always leaves the bit at 1
  assert_wake_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    setPu |=> puBit);

  // R2: a clear with no competing set drops the bit
  assert_clear_takes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clrPu && !setPu) |=> !puBit);

  // R4: while stopped, only a set can move the bit, whatever the processor does
  assert_cpu_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!puBit && cpuWe && !setPu) |=> !puBit);

  // R9: at every rising edge the enable equals the power-up bit
  assert_en_tracks_R9: assert property (@(posedge clk) disable iff (!rstN)
    clkEn == puBit);

  // R9: enable moves only while clk is low
  always @(clkEn) begin
    if (rstN) assert_en_low_R9: assert (!clk);
  end
endmodule

bind cgate_top cgate_chk u_chk (
  .clk(clk), .rstN(rstN), .puBit(puBit), .clkEn(clkEn),
  .setPu(strobe.setPu), .clrPu(strobe.clrPu), .cpuWe(cpuWe)
);

// File: tb/cgate_top_tb.sv
module cgate_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CFG_ADDR = 11;
  localparam int NUM_IRQ = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic cpuWe = 1'b0;
  logic cpuWdata = 1'b0;
  logic [NUM_IRQ-1:0] irqIn = '0;
  logic [DATA_W-1:0] cfgOut;
  logic clkEn, clkGated;

  int total = 0;
  int bad = 0;
  logic [DATA_W-1:0] expCfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgate_top u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .cpuWe(cpuWe), .cpuWdata(cpuWdata),
    .irqIn(irqIn), .cfgOut(cfgOut), .clkEn(clkEn), .clkGated(clkGated)
  );

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(string req, logic [DATA_W-1:0] cfgExp);
    total++;
    if (cfgOut !== cfgExp || clkEn !== cfgExp[0] || clkGated !== ~cfgExp[0]) begin
      bad++;
      $display("FAIL %s cfg=%h en=%b gated=%b expected cfg=%h en=%b gated=%b",
               req, cfgOut, clkEn, clkGated, cfgExp, cfgExp[0], ~cfgExp[0]);
    end
  endtask

  task automatic hostWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    tick();
    hostWe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    check("R1 reset", 8'h01);

    // R2 R3 R4 R5 sweep: start state x host(we,hit,bit) x cpu(we,bit)
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 32; c++) begin
        logic hwe, hit, hb, cwe, cb, cur;
        logic [DATA_W-1:0] word;
        hwe = c[0]; hit = c[1]; hb = c[2]; cwe = c[3]; cb = c[4];
        cur = s[0];
        word = {3'(c), 4'hA, cur};
        hostWrite(ADDR_W'(CFG_ADDR), word);
        expCfg = word;
        check("R2 setup", expCfg);
        hostWe = hwe;
        hostAddr = hit ? ADDR_W'(CFG_ADDR) : ADDR_W'(CFG_ADDR ^ 1);
        hostWdata = {3'(~c), 4'h5, hb};
        cpuWe = cwe; cpuWdata = cb;
        tick();
        hostWe = 1'b0; cpuWe = 1'b0;
        if (hwe && hit) expCfg = {3'(~c), 4'h5, hb};
        else if (cwe && cur) expCfg[0] = cb;
        if (hwe && hit && cwe) check("R5 host over cpu", expCfg);
        else if (hwe && !hit) check("R3 other address", expCfg);
        else if (cwe && !cur) check("R4 cpu ignored while stopped", expCfg);
        else check("R2 R4 write", expCfg);
      end
    end

    // R6 wake on each irq line, R7 held level, re-arm
    for (int i = 0; i < NUM_IRQ; i++) begin
      hostWrite(ADDR_W'(CFG_ADDR), 8'h30);
      check("R2 stop", 8'h30);
      irqIn[i] = 1'b1;
      tick(); check("R6 stage1", 8'h30);
      tick(); check("R6 stage2", 8'h30);
      tick(); check("R6 wake", 8'h31);
      cpuWe = 1'b1; cpuWdata = 1'b0; tick(); cpuWe = 1'b0;
      check("R4 cpu clear", 8'h30);
      tick(); tick(); tick();
      check("R7 held high no wake", 8'h30);
      irqIn[i] = 1'b0;
      tick(); tick(); tick();
      check("R7 fall no wake", 8'h30);
      irqIn[i] = 1'b1;
      tick(); tick(); tick();
      check("R6 re-arm wake", 8'h31);
      irqIn[i] = 1'b0;
      tick(); tick(); tick();
    end

    // R8 collision of wake edge with host clear
    hostWrite(ADDR_W'(CFG_ADDR), 8'h01);
    irqIn[1] = 1'b1;
    tick(); tick();
    hostWrite(ADDR_W'(CFG_ADDR), 8'h40);
    check("R8 wake beats clear", 8'h41);
    hostWrite(ADDR_W'(CFG_ADDR), 8'h40);
    check("R8 later clear works", 8'h40);
    irqIn[1] = 1'b0;
    tick(); tick(); tick();

    // R8 collision of wake edge with processor clear
    hostWrite(ADDR_W'(CFG_ADDR), 8'h41);
    irqIn[0] = 1'b1;
    tick(); tick();
    cpuWe = 1'b1; cpuWdata = 1'b0; tick(); cpuWe = 1'b0;
    check("R8 wake beats cpu clear", 8'h41);
    irqIn[0] = 1'b0;
    tick(); tick(); tick();

    // R9 R10 timing: enable follows bit only at the falling edge
    hostWe = 1'b1; hostAddr = ADDR_W'(CFG_ADDR); hostWdata = 8'h00;
    @(posedge clk); #1;
    hostWe = 1'b0;
    total++;
    if (clkEn !== 1'b1) begin
      bad++; $display("FAIL R9 en moved while clk high en=%b expected 1", clkEn);
    end
    tick();
    check("R9 R10 en low after fall", 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule